// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter that starts running when reset is released. It raises a one-cycle internal reset request when software fails to service it, or services it wrongly. Software services the counter by writing a fixed key byte to its refresh register. A correct write clears the counter, and counting starts again from zero.

Each timeout period has two parts. A closed stretch comes first and an open stretch follows it at the end. A key write that lands in the closed stretch counts as a fault. The size of the open stretch is 50 %, 75 % or 100 % of the period and comes from static option bits. The timeout length is also a static option: a power of two between 2^7 and 2^14 clock cycles.

Two exemptions apply. The first key write after reset release, or after a reset request, is accepted at any count. Clearing the standby-enable option bit opens the whole period.

Top module: `wwdt_top`

## Requirements
- R1: While `rst_n` is low, `rst_req` is low. Reset release leaves the count at zero and arms the first-write exemption.
- R2: The period P is 2^(7+`opt_tmo`) cycles. If no write is accepted, `rst_req` is high in the cycle that follows exactly P rising edges after the count restarted, and is low before that.
- R3: `rst_req` is high for one cycle only, unless a new fault occurs. The edge that raises it also restarts the count at zero and re-arms the first-write exemption.
- R4: A write of the key value 0xAC is accepted when the count is at or beyond the end of the closed stretch. It clears the count and raises no request.
- R5: A write of 0xAC while the count is inside the closed stretch raises `rst_req` in the next cycle, unless the exemption is armed.
- R6: `opt_win` encodes the window. With 01 the closed stretch is count < P/2. With 10 it is count < P/4. With 11 there is no closed stretch.
- R7: `opt_win` = 00 behaves the same as 11 (fully open).
- R8: When `opt_stby_en` is 0, the window is fully open whatever `opt_win` holds.
- R9: While the exemption is armed, a 0xAC write is accepted at any count and then disarms the exemption.
- R10: A write of any value other than 0xAC raises `rst_req` in the next cycle, even while the exemption is armed.
- R11: A 0xAC write on the final count P-1 is accepted and prevents the overflow. A wrong write on the final count produces a single one-cycle request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Refresh register write strobe |
| wr_data | input | 8 | Refresh register write data |
| opt_win | input | 2 | Window select option (static) |
| opt_stby_en | input | 1 | Standby-enable option; 0 forces a fully open window |
| opt_tmo | input | 3 | Timeout select; period is 2^(7+opt_tmo) |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
Refresh judgement and overflow detection can fall in the same cycle when a write arrives on the final count of a period. The bench waits until the count is exactly P-1 and then writes either the key or a wrong byte. For the key, it expects `rst_req` to stay low and the next overflow to come a full period later, which shows that the count restarted. For the wrong byte, it expects a single one-cycle request followed by a low output.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   typedef enum logic [1:0] {
      WIN_RSVD    = 2'b00,
      WIN_OPEN50  = 2'b01,
      WIN_OPEN75  = 2'b10,
      WIN_OPEN100 = 2'b11
   } win_sel_e;

   // Effective window after the standby flag and the reserved code are applied.
   function automatic win_sel_e eff_window(input logic [1:0] sel, input logic stby_en);
      win_sel_e w;
      if (!stby_en)
         w = WIN_OPEN100;
      else if (sel == 2'b00)
         w = WIN_OPEN100;
      else
         w = win_sel_e'(sel);
      return w;
   endfunction

endpackage

// File: rtl/wwdt_win_decode.sv
module wwdt_win_decode
   import wwdt_pkg::*;
#(
   parameter int unsigned TMO_BASE  = 7,
   parameter int unsigned TMO_SEL_W = 3,
   parameter int unsigned CNT_W     = TMO_BASE + (1 << TMO_SEL_W) - 1
) (
   input  logic [1:0]           opt_win,
   input  logic                 opt_stby_en,
   input  logic [TMO_SEL_W-1:0] opt_tmo,
   output logic [CNT_W-1:0]     term_cnt,
   output logic [CNT_W-1:0]     closed_end
);

   localparam int unsigned NOPT = 1 << TMO_SEL_W;

   logic [CNT_W-1:0] term_lut [NOPT];
   win_sel_e         win_eff;

   for (genvar g = 0; g < NOPT; g++) begin : g_term
      localparam int unsigned NB = TMO_BASE + g;
      assign term_lut[g] = {CNT_W{1'b1}} >> (CNT_W - NB);
   end

   assign term_cnt = term_lut[opt_tmo];
   assign win_eff  = eff_window(opt_win, opt_stby_en);

   always_comb begin
      unique case (win_eff)
         WIN_OPEN50:  closed_end = (term_cnt >> 1) + CNT_W'(1);
         WIN_OPEN75:  closed_end = (term_cnt >> 2) + CNT_W'(1);
         default:     closed_end = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown({opt_win, opt_stby_en, opt_tmo}))
         assert_window_order_R6: assert (closed_end <= term_cnt)
            else $error("closed stretch reaches past the terminal count");
   end

endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             refresh_ok,
   input  logic [CNT_W-1:0] term_cnt,
   output logic [CNT_W-1:0] cnt_q,
   output logic             at_term
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end

   assign at_term = (cnt_q == term_cnt);

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= term_cnt)
      else $error("count ran past the terminal value");

   assert_refresh_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_ok |=> (cnt_q == '0))
      else $error("accepted refresh did not restart the count");

endmodule

// File: rtl/wwdt_judge.sv
module wwdt_judge #(
   parameter int unsigned CNT_W  = 14,
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY = 8'hAC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic [CNT_W-1:0]  closed_end,
   input  logic              at_term,
   output logic              refresh_ok,
   output logic              cnt_clear,
   output logic              rst_req
);

   logic armed_q;
   logic key_wr;
   logic bad_wr;
   logic in_open;
   logic early_wr;
   logic overflow;
   logic fault;

   assign key_wr     = wr_en && (wr_data == KEY);
   assign bad_wr     = wr_en && (wr_data != KEY);
   assign in_open    = (cnt_q >= closed_end);
   assign refresh_ok = key_wr && (armed_q || in_open);
   assign early_wr   = key_wr && !refresh_ok;
   assign overflow   = at_term && !refresh_ok;
   assign fault      = bad_wr || early_wr || overflow;
   assign cnt_clear  = refresh_ok || fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         armed_q <= 1'b1;
      end else begin
         rst_req <= fault;
         if (fault)
            armed_q <= 1'b1;
         else if (refresh_ok)
            armed_q <= 1'b0;
      end
   end

   assert_req_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt_q == '0) && armed_q)
      else $error("request cycle without a restarted, re-armed state");

   assert_bad_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_data != KEY)) |=> rst_req)
      else $error("wrong value write did not raise a request");

   assert_closed_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_data == KEY) && !armed_q && (cnt_q < closed_end)) |=> rst_req)
      else $error("early key write did not raise a request");

   assert_first_exempt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_data == KEY) && armed_q) |=> !rst_req)
      else $error("exempt first key write raised a request");

endmodule

// File: rtl/wwdt_top.sv
module wwdt_top #(
   parameter int unsigned TMO_BASE  = 7,
   parameter int unsigned TMO_SEL_W = 3,
   parameter int unsigned DATA_W    = 8,
   parameter logic [DATA_W-1:0] KEY = 8'hAC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [1:0]           opt_win,
   input  logic                 opt_stby_en,
   input  logic [TMO_SEL_W-1:0] opt_tmo,
   output logic                 rst_req
);

   localparam int unsigned CNT_W = TMO_BASE + (1 << TMO_SEL_W) - 1;

   if (TMO_BASE < 3) begin : g_bad_base
      $error("TMO_BASE must be at least 3 so every window fraction is a whole count");
   end
   if (TMO_SEL_W < 1 || TMO_SEL_W > 4) begin : g_bad_sel
      $error("TMO_SEL_W must lie between 1 and 4");
   end
   if (CNT_W > 31) begin : g_bad_cnt
      $error("counter width too large");
   end

   logic [CNT_W-1:0] term_cnt;
   logic [CNT_W-1:0] closed_end;
   logic [CNT_W-1:0] cnt_q;
   logic             at_term;
   logic             refresh_ok;
   logic             cnt_clear;

   wwdt_win_decode #(
      .TMO_BASE  (TMO_BASE),
      .TMO_SEL_W (TMO_SEL_W),
      .CNT_W     (CNT_W)
   ) u_decode (
      .opt_win     (opt_win),
      .opt_stby_en (opt_stby_en),
      .opt_tmo     (opt_tmo),
      .term_cnt    (term_cnt),
      .closed_end  (closed_end)
   );

   wwdt_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (cnt_clear),
      .refresh_ok (refresh_ok),
      .term_cnt   (term_cnt),
      .cnt_q      (cnt_q),
      .at_term    (at_term)
   );

   wwdt_judge #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .KEY    (KEY)
   ) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .cnt_q      (cnt_q),
      .closed_end (closed_end),
      .at_term    (at_term),
      .refresh_ok (refresh_ok),
      .cnt_clear  (cnt_clear),
      .rst_req    (rst_req)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!rst_n -> !rst_req))
      else $error("request raised while held in reset");

endmodule

// File: tb/wwdt_top_tb_top.sv
`timescale 1ns/1ps
module wwdt_top_tb_top;

   localparam logic [7:0] KEY = 8'hAC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] opt_win = 2'b11;
   logic       opt_stby_en = 1'b1;
   logic [2:0] opt_tmo = 3'd0;
   logic       rst_req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   wwdt_top dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .opt_win     (opt_win),
      .opt_stby_en (opt_stby_en),
      .opt_tmo     (opt_tmo),
      .rst_req     (rst_req)
   );

   task automatic check(input logic got, input logic exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: rst_req=%0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic do_reset(input logic [1:0] w, input logic s, input logic [2:0] t);
      @(negedge clk);
      rst_n = 1'b0;
      opt_win = w;
      opt_stby_en = s;
      opt_tmo = t;
      repeat (3) @(negedge clk);
      check(rst_req, 1'b0, "R1 quiet in reset");
      rst_n = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_overflow(input logic [2:0] t);
      int p = 1 << (7 + t);
      do_reset(2'b11, 1'b1, t);
      idle(p - 1);
      check(rst_req, 1'b0, "R2 no request before P");
      idle(1);
      check(rst_req, 1'b1, "R2 request at P");
      idle(1);
      check(rst_req, 1'b0, "R3 one-cycle pulse");
   endtask

   task automatic t_rearm();
      do_reset(2'b01, 1'b1, 3'd0);
      idle(128);
      check(rst_req, 1'b1, "R3 overflow");
      wr(KEY);
      check(rst_req, 1'b0, "R3 exemption re-armed");
      idle(127);
      check(rst_req, 1'b0, "R3 restart after re-armed write");
      idle(1);
      check(rst_req, 1'b1, "R3 next overflow");
   endtask

   task automatic t_win50();
      do_reset(2'b01, 1'b1, 3'd0);
      idle(5);
      wr(KEY);
      check(rst_req, 1'b0, "R9 first write exempt");
      idle(63);
      wr(KEY);
      check(rst_req, 1'b1, "R5 key at count 63 in 50%");
      wr(KEY);
      check(rst_req, 1'b0, "R9 exempt after request");
      idle(64);
      wr(KEY);
      check(rst_req, 1'b0, "R4 R6 key at count 64 in 50%");
      idle(127);
      check(rst_req, 1'b0, "R4 count restarted");
      idle(1);
      check(rst_req, 1'b1, "R4 overflow after restart");
   endtask

   task automatic t_win75();
      do_reset(2'b10, 1'b1, 3'd0);
      wr(KEY);
      idle(31);
      wr(KEY);
      check(rst_req, 1'b1, "R6 key at count 31 in 75%");
      wr(KEY);
      idle(32);
      wr(KEY);
      check(rst_req, 1'b0, "R6 key at count 32 in 75%");
   endtask

   task automatic t_full(input logic [1:0] w, input logic s, input string req);
      do_reset(w, s, 3'd0);
      wr(KEY);
      idle(1);
      wr(KEY);
      check(rst_req, 1'b0, req);
      wr(KEY);
      check(rst_req, 1'b0, req);
   endtask

   task automatic t_bad_key();
      do_reset(2'b11, 1'b1, 3'd0);
      wr(8'h00);
      check(rst_req, 1'b1, "R10 wrong value while armed");
      idle(10);
      wr(8'hAD);
      check(rst_req, 1'b1, "R10 wrong value mid period");
      idle(1);
      check(rst_req, 1'b0, "R10 pulse ends");
   endtask

   task automatic t_same_cycle();
      do_reset(2'b01, 1'b1, 3'd0);
      wr(KEY);
      idle(127);
      wr(KEY);
      check(rst_req, 1'b0, "R11 key on final count accepted");
      idle(127);
      check(rst_req, 1'b0, "R11 full period after final-count key");
      idle(1);
      check(rst_req, 1'b1, "R11 next overflow");
      do_reset(2'b01, 1'b1, 3'd0);
      idle(127);
      wr(8'h3C);
      check(rst_req, 1'b1, "R11 wrong value on final count");
      idle(1);
      check(rst_req, 1'b0, "R11 single pulse");
   endtask

   initial begin
      idle(2);
      check(rst_req, 1'b0, "R1 reset state");
      t_overflow(3'd0);
      t_overflow(3'd1);
      t_overflow(3'd7);
      t_rearm();
      t_win50();
      t_win75();
      t_full(2'b01, 1'b0, "R8 standby flag clear opens window");
      t_full(2'b00, 1'b1, "R7 reserved code fully open");
      t_full(2'b11, 1'b1, "R6 code 11 fully open");
      t_bad_key();
      t_same_cycle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule